// File: doc/BRIEF.md
# Control register mode unit

This unit keeps the two main processor control registers (the machine-control word, called CR0 here, and the feature-control word, CR4), the long-mode enable and long-mode active bits, and the mask that gates physical address bit 20. Software-visible writes reach it as a stream of requests carrying a register select and a data word. From those writes it maintains a compact vector of hidden mode flags that the rest of the core reads every cycle: protected mode, segment-base-add, the three FPU trap controls, long mode, 64-bit code and extended FPU save enable.

Two derived events leave the block as single-cycle pulses. The first asks the translation cache to be flushed when a paging-relevant bit changes or the address-bit-20 gate moves. The second tells the fetch logic to cut its instruction pointer to 32 bits when long mode is left. Long-mode entry is refused, and the whole write dropped, when physical address extension is not enabled at the moment paging is switched on with long mode enabled.

The write port uses valid/ready. `wr_ready` is held high at all times: every request is taken on the clock edge where `wr_valid` is high, and the unit never applies back-pressure. Only one write can be presented per cycle, so a CR0 write always sees the values of CR4 and the long-mode enable bit as they stood before that edge.

Top module: `cr_mode_unit`

## Requirements
- R1: While and after reset, CR0 reads 0x60000010, CR4 reads 0, the long-mode enable and active bits are 0, the bit-20 mask is 0xFFFFFFFF, `hflags` is 0x02, and `flush_req`, `ip_trunc` are 0.
- R2: An accepted write with `wr_sel`=0 stores `wr_data` in CR0 with bit 4 forced to 1, visible the cycle after the strobe.
- R3: `flush_req` is high for exactly the cycle after an edge where an accepted CR0 write changed bit 31, 16 or 0, a CR4 write changed bit 7, 5 or 4, or `a20_gate` differed from mask bit 20; otherwise it is low.
- R4: A CR0 write that raises bit 31 while bit 31 was 0, the enable bit is 1 and CR4 bit 5 is 1 sets the active bit and `hflags` bit 5.
- R5: The same write with CR4 bit 5 clear is refused: CR0, the flags and the active bit stay unchanged and no flush is requested.
- R6: A CR0 write that clears bit 31 while the active bit is 1 clears the active bit and `hflags` bits 5 and 6, and pulses `ip_trunc` high for one cycle.
- R7: After every accepted CR0 write, `hflags` bit 0 equals CR0 bit 0 and `hflags` bit 1 equals its inverse.
- R8: `hflags` bits 4:2 equal CR0 bits 3:1 (bit 2 from CR0 bit 1).
- R9: A write with `wr_sel`=1 stores `wr_data` in CR4, with bit 9 cleared when `sse_ok` is 0; `hflags` bit 7 equals stored CR4 bit 9.
- R10: `a20_mask` equals 0xFFEFFFFF with bit 20 set to `a20_gate` as sampled on the previous edge.
- R11: A write with `wr_sel`=2 loads the enable bit from `wr_data` bit 0; a write with `wr_sel`=3 changes no state; `wr_ready` is always 1.
- R12: A `cs_load` pulse sets `hflags` bit 6 to `cs_long` only when the active bit is 1 before the edge, and clears it otherwise; a long-mode exit on the same edge wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted (always 1) |
| wr_sel | input | 2 | 0 CR0, 1 CR4, 2 long-mode enable, 3 unused |
| wr_data | input | DATA_W | Write data |
| sse_ok | input | 1 | Streaming SIMD support present |
| a20_gate | input | 1 | Address bit 20 gate state |
| cs_load | input | 1 | Code segment loaded this cycle |
| cs_long | input | 1 | Loaded code segment is 64-bit |
| cr0_q | output | DATA_W | CR0 value |
| cr4_q | output | DATA_W | CR4 value |
| lme_q | output | 1 | Long-mode enable |
| lma_q | output | 1 | Long-mode active |
| hflags | output | 8 | {fxsr, code64, long, ts, em, mp, segadd, prot} |
| a20_mask | output | DATA_W | Physical address mask |
| flush_req | output | 1 | One-cycle translation flush request |
| ip_trunc | output | 1 | One-cycle instruction pointer truncate command |

## Verification
A directed sequence walks CR0 through writes that leave the paging-relevant bits alone and writes that toggle protected mode, which separates the flush condition from a plain data change. CR4 is written with and without SIMD support to tell the feature clearing apart from the stored value, and the long-mode path is driven through a permitted entry, a code segment load, an exit and a refused entry, which distinguishes the refuse rule from the ordinary paging toggle. A gate toggle on bit 20 is checked in isolation, and a long stretch of random writes, gate moves and segment loads then exposes interactions such as a flush raised by two sources on one edge, all compared against a behavioural model every cycle.

// File: rtl/crm_pkg.sv
package crm_pkg;
  // CR0 bit positions
  localparam int C0_PE  = 0;
  localparam int C0_MP  = 1;
  localparam int C0_ET  = 4;
  localparam int C0_WP  = 16;
  localparam int C0_PG  = 31;
  // CR4 bit positions
  localparam int C4_PSE = 4;
  localparam int C4_PAE = 5;
  localparam int C4_PGE = 7;
  localparam int C4_FXS = 9;
  // gated address bit
  localparam int GATE_BIT = 20;

  typedef enum logic [1:0] {
    SEL_CR0 = 2'd0,
    SEL_CR4 = 2'd1,
    SEL_EXT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic fxsr;
    logic code64;
    logic longm;
    logic [2:0] fpu;
    logic segadd;
    logic prot;
  } hflag_t;
endpackage

// File: rtl/crm_cr0_unit.sv
module crm_cr0_unit
  import crm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RST_VAL = 32'h6000_0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr0,
  input  logic              wr_ext,
  input  logic [DATA_W-1:0] data,
  input  logic              pae_on,
  input  logic              cs_load,
  input  logic              cs_long,
  output logic [DATA_W-1:0] cr0,
  output logic              lme,
  output logic              lma,
  output logic              code64,
  output logic              segadd,
  output logic              flush_hit,
  output logic              leave_hit
);
  localparam logic [DATA_W-1:0] PAGE_MASK =
    (DATA_W'(1) << C0_PG) | (DATA_W'(1) << C0_WP) | (DATA_W'(1) << C0_PE);
  localparam logic [DATA_W-1:0] ET_MASK = DATA_W'(1) << C0_ET;

  logic enter, refuse, accept;

  always_comb begin
    enter     = wr0 && !cr0[C0_PG] && data[C0_PG] && lme;
    refuse    = enter && !pae_on;
    accept    = wr0 && !refuse;
    leave_hit = wr0 && cr0[C0_PG] && !data[C0_PG] && lma;
    flush_hit = accept && (((data ^ cr0) & PAGE_MASK) != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr0    <= RST_VAL;
      segadd <= ~RST_VAL[C0_PE];
      lme    <= 1'b0;
      lma    <= 1'b0;
      code64 <= 1'b0;
    end else begin
      if (accept) begin
        cr0    <= data | ET_MASK;
        segadd <= ~data[C0_PE];
      end
      if (wr_ext) lme <= data[0];
      if (enter && !refuse) lma <= 1'b1;
      else if (leave_hit)   lma <= 1'b0;
      if (leave_hit)        code64 <= 1'b0;
      else if (cs_load)     code64 <= cs_long && lma;
    end
  end
endmodule

// File: rtl/crm_cr4_unit.sv
module crm_cr4_unit
  import crm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr4,
  input  logic [DATA_W-1:0] data,
  input  logic              sse_ok,
  output logic [DATA_W-1:0] cr4,
  output logic              flush_hit
);
  localparam logic [DATA_W-1:0] PAGE_MASK =
    (DATA_W'(1) << C4_PGE) | (DATA_W'(1) << C4_PAE) | (DATA_W'(1) << C4_PSE);
  localparam logic [DATA_W-1:0] FXS_MASK = DATA_W'(1) << C4_FXS;

  logic [DATA_W-1:0] filt;

  always_comb begin
    filt      = sse_ok ? data : (data & ~FXS_MASK);
    flush_hit = wr4 && (((filt ^ cr4) & PAGE_MASK) != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   cr4 <= '0;
    else if (wr4) cr4 <= filt;
  end
endmodule

// File: rtl/crm_gate_unit.sv
module crm_gate_unit
  import crm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate,
  output logic [DATA_W-1:0] mask,
  output logic              flush_hit
);
  logic gate_q;

  always_comb begin
    flush_hit = gate != gate_q;
    mask      = '1;
    mask[GATE_BIT] = gate_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b1;
    else        gate_q <= gate;
  end
endmodule

// File: rtl/cr_mode_unit.sv
module cr_mode_unit
  import crm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] CR0_RST = 32'h6000_0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sse_ok,
  input  logic              a20_gate,
  input  logic              cs_load,
  input  logic              cs_long,
  output logic [DATA_W-1:0] cr0_q,
  output logic [DATA_W-1:0] cr4_q,
  output logic              lme_q,
  output logic              lma_q,
  output logic [7:0]        hflags,
  output logic [DATA_W-1:0] a20_mask,
  output logic              flush_req,
  output logic              ip_trunc
);
  logic wr0, wr4, wr_ext;
  logic f0, f4, fg, leave;
  logic code64, segadd;
  hflag_t hf;

  assign wr_ready = 1'b1;

  always_comb begin
    wr0    = wr_valid && (reg_sel_e'(wr_sel) == SEL_CR0);
    wr4    = wr_valid && (reg_sel_e'(wr_sel) == SEL_CR4);
    wr_ext = wr_valid && (reg_sel_e'(wr_sel) == SEL_EXT);
  end

  crm_cr0_unit #(.DATA_W(DATA_W), .RST_VAL(CR0_RST)) u_cr0 (
    .clk(clk), .rst_n(rst_n), .wr0(wr0), .wr_ext(wr_ext), .data(wr_data),
    .pae_on(cr4_q[C4_PAE]), .cs_load(cs_load), .cs_long(cs_long),
    .cr0(cr0_q), .lme(lme_q), .lma(lma_q), .code64(code64), .segadd(segadd),
    .flush_hit(f0), .leave_hit(leave)
  );

  crm_cr4_unit #(.DATA_W(DATA_W)) u_cr4 (
    .clk(clk), .rst_n(rst_n), .wr4(wr4), .data(wr_data), .sse_ok(sse_ok),
    .cr4(cr4_q), .flush_hit(f4)
  );

  crm_gate_unit #(.DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .gate(a20_gate), .mask(a20_mask), .flush_hit(fg)
  );

  always_comb begin
    hf.fxsr   = cr4_q[C4_FXS];
    hf.code64 = code64;
    hf.longm  = lma_q;
    hf.fpu    = cr0_q[C0_MP +: 3];
    hf.segadd = segadd;
    hf.prot   = cr0_q[C0_PE];
    hflags    = hf;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_req <= 1'b0;
      ip_trunc  <= 1'b0;
    end else begin
      flush_req <= f0 | f4 | fg;
      ip_trunc  <= leave;
    end
  end
endmodule

// File: rtl/cr_mode_chk.sv
module cr_mode_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [1:0]        wr_sel,
  input logic              sse_ok,
  input logic              a20_gate,
  input logic [DATA_W-1:0] cr0_q,
  input logic [DATA_W-1:0] cr4_q,
  input logic              lme_q,
  input logic              lma_q,
  input logic [7:0]        hflags,
  input logic [DATA_W-1:0] a20_mask,
  input logic              flush_req,
  input logic              ip_trunc
);
  AST_ET_ALWAYS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cr0_q[4]); // R2

  AST_FLUSH_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> ($past(wr_valid) || ($past(a20_gate) != $past(a20_mask[20])))); // R3

  AST_ENTRY_NEEDS_PAE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lma_q) |-> (cr4_q[5] && cr0_q[31] && lme_q && hflags[5])); // R4

  AST_TRUNC_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ip_trunc |-> (!lma_q && !cr0_q[31] && !hflags[6])); // R6

  AST_SEGADD_REAL: assert property (@(posedge clk) disable iff (!rst_n)
    !hflags[0] |-> hflags[1]); // R7

  AST_FXSR_NEEDS_SSE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_valid && wr_sel == 2'd1 && !sse_ok) |-> !cr4_q[9]); // R9

  AST_A20_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (a20_mask | (DATA_W'(1) << 20)) == '1); // R10

  AST_CODE64_IN_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    hflags[6] |-> hflags[5]); // R12
endmodule

bind cr_mode_unit cr_mode_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel),
  .sse_ok(sse_ok), .a20_gate(a20_gate), .cr0_q(cr0_q), .cr4_q(cr4_q),
  .lme_q(lme_q), .lma_q(lma_q), .hflags(hflags), .a20_mask(a20_mask),
  .flush_req(flush_req), .ip_trunc(ip_trunc)
);

// File: tb/cr_mode_unit_test.sv
module cr_mode_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [1:0] wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic sse_ok = 1'b0;
  logic a20_gate = 1'b1;
  logic cs_load = 1'b0;
  logic cs_long = 1'b0;
  logic [31:0] cr0_q, cr4_q, a20_mask;
  logic lme_q, lma_q, flush_req, ip_trunc;
  logic [7:0] hflags;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  cr_mode_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .sse_ok(sse_ok), .a20_gate(a20_gate),
    .cs_load(cs_load), .cs_long(cs_long), .cr0_q(cr0_q), .cr4_q(cr4_q),
    .lme_q(lme_q), .lma_q(lma_q), .hflags(hflags), .a20_mask(a20_mask),
    .flush_req(flush_req), .ip_trunc(ip_trunc)
  );

  // behavioural reference model
  logic [31:0] m_cr0, m_cr4;
  bit m_lme, m_lma, m_c64, m_seg, m_gate, m_flush, m_trunc;

  always @(posedge clk) begin
    bit fl, tr, nlma, nc64;
    if (!rst_n) begin
      m_cr0 = 32'h6000_0010; m_cr4 = 0; m_lme = 0; m_lma = 0; m_c64 = 0;
      m_seg = 1; m_gate = 1; m_flush = 0; m_trunc = 0;
    end else begin
      fl = (a20_gate != m_gate);
      tr = 0;
      nlma = m_lma;
      nc64 = cs_load ? (cs_long && m_lma) : m_c64;
      if (wr_valid && wr_sel == 2'd0) begin
        if (!m_cr0[31] && wr_data[31] && m_lme && !m_cr4[5]) begin
          // refused entry: nothing changes
        end else begin
          if ((wr_data[31] != m_cr0[31]) || (wr_data[16] != m_cr0[16]) ||
              (wr_data[0] != m_cr0[0])) fl = 1;
          if (!m_cr0[31] && wr_data[31] && m_lme) nlma = 1;
          if (m_cr0[31] && !wr_data[31] && m_lma) begin
            nlma = 0; nc64 = 0; tr = 1;
          end
          m_cr0 = wr_data | 32'h10;
          m_seg = !wr_data[0];
        end
      end else if (wr_valid && wr_sel == 2'd1) begin
        logic [31:0] v;
        v = wr_data;
        if (!sse_ok) v[9] = 0;
        if ((v[7] != m_cr4[7]) || (v[5] != m_cr4[5]) || (v[4] != m_cr4[4])) fl = 1;
        m_cr4 = v;
      end else if (wr_valid && wr_sel == 2'd2) begin
        m_lme = wr_data[0];
      end
      m_lma = nlma; m_c64 = nc64;
      m_gate = a20_gate; m_flush = fl; m_trunc = tr;
    end
  end

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2", "cr0", cr0_q, m_cr0);
      check("R9", "cr4", cr4_q, m_cr4);
      check("R11", "lme", 32'(lme_q), 32'(m_lme));
      check("R4", "lma", 32'(lma_q), 32'(m_lma));
      check("R3", "flush", 32'(flush_req), 32'(m_flush));
      check("R6", "trunc", 32'(ip_trunc), 32'(m_trunc));
      check("R7", "prot/segadd", 32'(hflags[1:0]), 32'({m_seg, m_cr0[0]}));
      check("R8", "fpu", 32'(hflags[4:2]), 32'(m_cr0[3:1]));
      check("R12", "code64/long", 32'(hflags[6:5]), 32'({m_c64, m_lma}));
      check("R9", "fxsr", 32'(hflags[7]), 32'(m_cr4[9]));
      check("R10", "a20", a20_mask, 32'hFFEF_FFFF | (32'(m_gate) << 20));
      check("R11", "ready", 32'(wr_ready), 32'd1);
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
    end
  end

  task automatic wr(logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    wr_valid = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_valid = 0; wr_data = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] save0;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", "cr0 reset", cr0_q, 32'h6000_0010);
    check("R1", "cr4 reset", cr4_q, 32'h0);
    check("R1", "hflags reset", 32'(hflags), 32'h02);
    check("R1", "a20 reset", a20_mask, 32'hFFFF_FFFF);
    check("R1", "pulses reset", 32'({flush_req, ip_trunc, lme_q, lma_q}), 32'h0);

    wr(2'd0, 32'h0000_0000);                 // no paging bit change
    check("R2", "et forced", cr0_q, 32'h10);
    check("R3", "no flush", 32'(flush_req), 32'd0);
    wr(2'd0, 32'h0000_000F);                 // PE set
    check("R3", "pe flush", 32'(flush_req), 32'd1);
    check("R8", "fpu bits", 32'(hflags[4:2]), 32'h7);
    idle(1);
    check("R3", "pulse one cycle", 32'(flush_req), 32'd0);
    wr(2'd1, 32'h0000_0200);                 // no SSE
    check("R9", "osfxsr cleared", cr4_q, 32'h0);
    sse_ok = 1;
    wr(2'd1, 32'h0000_02A0);
    check("R9", "fxsr flag", 32'(hflags[7]), 32'd1);
    wr(2'd3, 32'hFFFF_FFFF);                 // unused select
    check("R11", "sel3 ignored", cr0_q, 32'h1F);
    wr(2'd2, 32'h1);
    check("R11", "lme set", 32'(lme_q), 32'd1);
    wr(2'd0, 32'h8000_0001);                 // entry
    check("R4", "entered", 32'({lma_q, hflags[5]}), 32'h3);
    @(negedge clk); cs_load = 1; cs_long = 1;
    @(negedge clk); cs_load = 0; cs_long = 0;
    check("R12", "code64 set", 32'(hflags[6]), 32'd1);
    wr(2'd0, 32'h0000_0001);                 // exit
    check("R6", "exit pulse", 32'({ip_trunc, lma_q, hflags[6]}), 32'h4);
    idle(1);
    check("R6", "trunc one cycle", 32'(ip_trunc), 32'd0);
    wr(2'd1, 32'h0000_0080);                 // clear PAE
    save0 = cr0_q;
    wr(2'd0, 32'h8000_0001);                 // refused
    check("R5", "refused cr0", cr0_q, save0);
    check("R5", "refused lma/flush", 32'({lma_q, flush_req}), 32'h0);
    @(negedge clk); cs_load = 1; cs_long = 1;
    @(negedge clk); cs_load = 0; cs_long = 0;
    check("R12", "code64 needs long", 32'(hflags[6]), 32'd0);
    @(negedge clk); a20_gate = 0;
    @(negedge clk);
    check("R10", "a20 low", a20_mask, 32'hFFEF_FFFF);
    check("R3", "a20 flush", 32'(flush_req), 32'd1);
    a20_gate = 1;
    idle(2);
    check("R10", "a20 high", a20_mask, 32'hFFFF_FFFF);

    // random stretch
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      wr_valid = ($urandom % 3) != 0;
      wr_sel   = 2'($urandom);
      wr_data  = $urandom;
      if (($urandom % 4) == 0) wr_data[31] = 0;
      sse_ok   = ($urandom % 4) != 0;
      if (($urandom % 8) == 0) a20_gate = ~a20_gate;
      cs_load  = ($urandom % 5) == 0;
      cs_long  = 1'($urandom);
    end
    @(negedge clk);
    wr_valid = 0; cs_load = 0;
    idle(3);
    summary();
  end
endmodule